// File: doc/BRIEF.md
# Secure Real-Time Clock Register Block

This block keeps time for a chip on a plain 32-bit word-addressed register bus. A sub-second fraction counter advances on an external tick input. When the fraction rolls over, a 32-bit seconds counter increments. An alarm pair made of a seconds value and a fraction value is compared against the running time and latches a flag when the time matches.

Bus writes are not applied at once. Each accepted write is held in a single-entry write engine for a fixed number of cycles before it lands in its register. During that window the engine reports busy. When the write lands, a completion flag is raised. A write that arrives while the engine is busy is thrown away and raises an error flag. A polling master therefore always learns within a bounded time whether its write took effect.

The block starts in a non-valid state. In that state time does not advance. It also refuses to count until software has loaded the seconds register at least once since reset. A violation input forces the block back into the non-valid state. A single interrupt line combines the four maskable flags with their enable bits.

Top module: `vault_rtc`

## Requirements
- R1: After reset the seconds, fraction, control and interrupt-enable words read 0. The alarm seconds word reads all ones and the alarm fraction word reads 0. The status word reads 0x202, which means non-valid (bit 1) and write-next (bit 9) are set. The irq output is 0.
- R2: A write captured at a clock edge sets write-busy (status bit 10) for exactly WR_LAT cycles. During those cycles write-next (bit 9) reads as the inverse of busy. At the end of the window the target register takes the value and write-complete (bit 8) becomes set.
- R3: A write presented while busy is set is discarded, so its target keeps its old value. It sets write-error (status bit 7). The write already in flight still completes normally.
- R4: Status flags are cleared by committed writes of 1 to their bit positions: bit 8, bit 7, bit 4 and bit 0. Bit 0 alone clears only the violation flag. Non-valid (bit 1) clears only when bits 1 and 0 are written as 1 in the same write.
- R5: The counters advance only when all of the following hold: control bit 3 is set, non-valid is clear, and the seconds word (offset 0) has been written since reset. Otherwise ticks leave both seconds and fraction unchanged.
- R6: The fraction occupies the low FRAC_W bits of offset 1 and increments once per cycle with tick high. When it wraps from all ones to 0 the seconds word increments, and the seconds word itself wraps from all ones to 0. Writing the seconds word leaves the fraction unchanged.
- R7: The alarm flag (status bit 4) sets on the cycle after seconds equals the alarm seconds word (offset 2) and the fraction equals the alarm fraction word (offset 3). The flag is sticky. An alarm seconds value of all ones never sets it.
- R8: irq is 1 exactly when some status bit among 9, 8, 7 and 4 is set together with the same bit of the interrupt-enable word (offset 6).
- R9: Reads have no side effects. Offset 7 reads 0. Control reads back only bit 3 and interrupt-enable reads back only bits 9, 8, 7 and 4. Register offsets are: 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status, 6 interrupt enable.
- R10: A high cycle on viol_in sets both the violation flag (bit 0) and non-valid (bit 1), which stops the counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word offset for both read and write |
| bus_wen | input | 1 | Write request, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| tick | input | 1 | Fraction advance strobe |
| viol_in | input | 1 | Security violation event |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a second write that lands inside the busy window. The bench handles this by driving a second write request on the cycle right after the first is captured. It then checks that the first target updated, the second did not, and the error flag is set. The other hard corner is an armed-looking alarm at seconds all ones. To reach it, the bench preloads the seconds word to all ones with the fraction one step below the alarm fraction, ticks straight through the match with the alarm unset, and then ticks once more to watch the seconds word wrap to zero.

// File: rtl/vault_rtc_pkg.sv
package vault_rtc_pkg;

   typedef enum logic [2:0] {
      RG_SEC   = 3'd0,
      RG_FRAC  = 3'd1,
      RG_ASEC  = 3'd2,
      RG_AFRAC = 3'd3,
      RG_CTRL  = 3'd4,
      RG_STAT  = 3'd5,
      RG_IEN   = 3'd6
   } rtc_reg_e;

   localparam int unsigned B_BUSY = 10;
   localparam int unsigned B_NEXT = 9;
   localparam int unsigned B_DONE = 8;
   localparam int unsigned B_ERR  = 7;
   localparam int unsigned B_ALM  = 4;
   localparam int unsigned B_NV   = 1;
   localparam int unsigned B_SV   = 0;
   localparam int unsigned B_RUN  = 3;

   localparam int unsigned MIN_DATA_W = B_BUSY + 1;

endpackage

// File: rtl/vault_rtc_wr.sv
module vault_rtc_wr
   import vault_rtc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WR_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wen,
   input  logic [2:0]        waddr,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic              commit,
   output logic              drop,
   output logic [2:0]        c_addr,
   output logic [DATA_W-1:0] c_data
);

   localparam int unsigned CNT_W = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;

   logic accept;

   assign accept = wen && !busy;
   assign drop   = wen && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_addr <= '0;
         c_data <= '0;
      end else if (accept) begin
         c_addr <= waddr;
         c_data <= wdata;
      end
   end

   generate
      if (WR_LAT == 1) begin : g_lat_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      busy <= 1'b0;
            else if (accept) busy <= 1'b1;
            else if (busy)   busy <= 1'b0;
         end
         assign commit = busy;
      end else begin : g_lat_cnt
         logic [CNT_W-1:0] remain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy   <= 1'b0;
               remain <= '0;
            end else if (accept) begin
               busy   <= 1'b1;
               remain <= CNT_W'(WR_LAT - 1);
            end else if (busy) begin
               if (remain == '0) busy <= 1'b0;
               else              remain <= remain - 1'b1;
            end
         end
         assign commit = busy && (remain == '0);
      end
   endgenerate

endmodule

// File: rtl/vault_rtc_cnt.sv
module vault_rtc_cnt #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FRAC_W     = 15,
   parameter bit          ALARM_FRAC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              allow,
   input  logic              tick,
   input  logic              sec_we,
   input  logic              frac_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] asec,
   input  logic [FRAC_W-1:0] afrac,
   output logic [DATA_W-1:0] sec_q,
   output logic [FRAC_W-1:0] frac_q,
   output logic              loaded,
   output logic              hit
);

   logic step;
   logic frac_wrap;

   assign step      = allow && loaded && tick;
   assign frac_wrap = (frac_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= '0;
         frac_q <= '0;
         loaded <= 1'b0;
      end else begin
         if (step) begin
            frac_q <= frac_q + 1'b1;
            if (frac_wrap) sec_q <= sec_q + 1'b1;
         end
         if (frac_we) frac_q <= wdata[FRAC_W-1:0];
         if (sec_we) begin
            sec_q  <= wdata;
            loaded <= 1'b1;
         end
      end
   end

   logic armed;
   assign armed = (asec != '1);

   generate
      if (ALARM_FRAC) begin : g_cmp_full
         assign hit = armed && (sec_q == asec) && (frac_q == afrac);
      end else begin : g_cmp_sec
         assign hit = armed && (sec_q == asec);
      end
   endgenerate

endmodule

// File: rtl/vault_rtc_irq.sv
module vault_rtc_irq
   import vault_rtc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] stat,
   input  logic [DATA_W-1:0] ien,
   output logic              irq
);

   localparam int unsigned NSRC = 4;
   localparam int unsigned SRC_BIT [NSRC] = '{B_NEXT, B_DONE, B_ERR, B_ALM};

   logic [NSRC-1:0] src;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         assign src[i] = stat[SRC_BIT[i]] && ien[SRC_BIT[i]];
      end
   endgenerate

   assign irq = |src;

endmodule

// File: rtl/vault_rtc.sv
module vault_rtc
   import vault_rtc_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FRAC_W     = 15,
   parameter int unsigned WR_LAT     = 4,
   parameter bit          ALARM_FRAC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wen,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick,
   input  logic              viol_in,
   output logic              irq
);

   localparam logic [DATA_W-1:0] IEN_MASK =
      (DATA_W'(1) << B_NEXT) | (DATA_W'(1) << B_DONE) |
      (DATA_W'(1) << B_ERR)  | (DATA_W'(1) << B_ALM);

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_width
         $error("vault_rtc: DATA_W too small for the status layout");
      end
      if (FRAC_W < 1 || FRAC_W >= DATA_W) begin : g_bad_frac
         $error("vault_rtc: FRAC_W must be in 1..DATA_W-1");
      end
      if (WR_LAT < 1) begin : g_bad_lat
         $error("vault_rtc: WR_LAT must be at least 1");
      end
   endgenerate

   logic              busy, commit, drop;
   logic [2:0]        c_addr;
   logic [DATA_W-1:0] c_data;

   vault_rtc_wr #(.DATA_W(DATA_W), .WR_LAT(WR_LAT)) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wen    (bus_wen),
      .waddr  (bus_addr),
      .wdata  (bus_wdata),
      .busy   (busy),
      .commit (commit),
      .drop   (drop),
      .c_addr (c_addr),
      .c_data (c_data)
   );

   logic st_w;
   assign st_w = commit && (c_addr == RG_STAT);

   logic              run_q;
   logic [DATA_W-1:0] asec_q;
   logic [FRAC_W-1:0] afrac_q;
   logic [DATA_W-1:0] ien_q;
   logic              wc_q, we_q, caf_q, nv_q, sv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         asec_q  <= '1;
         afrac_q <= '0;
         ien_q   <= '0;
      end else if (commit) begin
         unique case (c_addr)
            RG_CTRL:  run_q   <= c_data[B_RUN];
            RG_ASEC:  asec_q  <= c_data;
            RG_AFRAC: afrac_q <= c_data[FRAC_W-1:0];
            RG_IEN:   ien_q   <= c_data & IEN_MASK;
            default: ;
         endcase
      end
   end

   logic [DATA_W-1:0] sec_q;
   logic [FRAC_W-1:0] frac_q;
   logic              loaded, hit;

   vault_rtc_cnt #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ALARM_FRAC(ALARM_FRAC)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .allow   (run_q && !nv_q),
      .tick    (tick),
      .sec_we  (commit && (c_addr == RG_SEC)),
      .frac_we (commit && (c_addr == RG_FRAC)),
      .wdata   (c_data),
      .asec    (asec_q),
      .afrac   (afrac_q),
      .sec_q   (sec_q),
      .frac_q  (frac_q),
      .loaded  (loaded),
      .hit     (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wc_q  <= 1'b0;
         we_q  <= 1'b0;
         caf_q <= 1'b0;
         nv_q  <= 1'b1;
         sv_q  <= 1'b0;
      end else begin
         if (st_w && c_data[B_DONE]) wc_q <= 1'b0;
         else if (commit)            wc_q <= 1'b1;

         if (drop)                       we_q <= 1'b1;
         else if (st_w && c_data[B_ERR]) we_q <= 1'b0;

         if (hit)                        caf_q <= 1'b1;
         else if (st_w && c_data[B_ALM]) caf_q <= 1'b0;

         if (viol_in)                   sv_q <= 1'b1;
         else if (st_w && c_data[B_SV]) sv_q <= 1'b0;

         if (viol_in)                                    nv_q <= 1'b1;
         else if (st_w && c_data[B_NV] && c_data[B_SV])  nv_q <= 1'b0;
      end
   end

   logic [DATA_W-1:0] stat_w;
   always_comb begin
      stat_w         = '0;
      stat_w[B_BUSY] = busy;
      stat_w[B_NEXT] = !busy;
      stat_w[B_DONE] = wc_q;
      stat_w[B_ERR]  = we_q;
      stat_w[B_ALM]  = caf_q;
      stat_w[B_NV]   = nv_q;
      stat_w[B_SV]   = sv_q;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         RG_SEC:   bus_rdata = sec_q;
         RG_FRAC:  bus_rdata = DATA_W'(frac_q);
         RG_ASEC:  bus_rdata = asec_q;
         RG_AFRAC: bus_rdata = DATA_W'(afrac_q);
         RG_CTRL:  bus_rdata[B_RUN] = run_q;
         RG_STAT:  bus_rdata = stat_w;
         RG_IEN:   bus_rdata = ien_q;
         default:  bus_rdata = '0;
      endcase
   end

   vault_rtc_irq #(.DATA_W(DATA_W)) u_irq (
      .stat (stat_w),
      .ien  (ien_q),
      .irq  (irq)
   );

endmodule

// File: rtl/vault_rtc_chk.sv
module vault_rtc_chk
   import vault_rtc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FRAC_W = 15,
   parameter int unsigned WR_LAT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wen,
   input logic              busy,
   input logic              commit,
   input logic [2:0]        c_addr,
   input logic [DATA_W-1:0] c_data,
   input logic [DATA_W-1:0] stat_w,
   input logic [DATA_W-1:0] ien_q,
   input logic              irq,
   input logic              run_q,
   input logic              nv_q,
   input logic              loaded,
   input logic [DATA_W-1:0] sec_q,
   input logic [FRAC_W-1:0] frac_q,
   input logic [DATA_W-1:0] asec_q
);

   logic [31:0] busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   // R2: the busy window never outlasts the write latency
   p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run < WR_LAT));

   // R2: the end of a write raises completion unless that write cleared it
   p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(c_addr == RG_STAT && c_data[B_DONE])) |-> stat_w[B_DONE]);

   // R3: a request during busy raises the error flag
   p_drop_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && busy) |=> stat_w[B_ERR]);

   // R4: leaving non-valid needs both low status bits written together
   p_nv_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nv_q) |-> $past(commit && c_addr == RG_STAT && c_data[B_NV] && c_data[B_SV]));

   // R5: when counting is not allowed, time holds unless a write lands
   p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run_q && !nv_q && loaded) && !commit) |=> ($stable(sec_q) && $stable(frac_q)));

   // R7: an unset alarm never raises the alarm flag
   p_no_alarm_unset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (asec_q == '1 && !stat_w[B_ALM]) |=> !stat_w[B_ALM]);

   // R8: no enables, no interrupt
   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq);

endmodule

bind vault_rtc vault_rtc_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .WR_LAT(WR_LAT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_wen (bus_wen),
   .busy    (busy),
   .commit  (commit),
   .c_addr  (c_addr),
   .c_data  (c_data),
   .stat_w  (stat_w),
   .ien_q   (ien_q),
   .irq     (irq),
   .run_q   (run_q),
   .nv_q    (nv_q),
   .loaded  (loaded),
   .sec_q   (sec_q),
   .frac_q  (frac_q),
   .asec_q  (asec_q)
);

// File: tb/tb_vault_rtc.sv
`timescale 1ns/1ps
module tb_vault_rtc;

   localparam int unsigned DW  = 32;
   localparam int unsigned FW  = 4;
   localparam int unsigned LAT = 3;

   localparam logic [2:0] A_SEC = 3'd0, A_FRAC = 3'd1, A_ASEC = 3'd2, A_AFRAC = 3'd3,
                          A_CTRL = 3'd4, A_STAT = 3'd5, A_IEN = 3'd6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic          bus_wen = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          tick = 1'b0;
   logic          viol_in = 1'b0;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   vault_rtc #(.DATA_W(DW), .FRAC_W(FW), .WR_LAT(LAT), .ALARM_FRAC(1'b1)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wen   (bus_wen),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick      (tick),
      .viol_in   (viol_in),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
      bus_addr = a;
      #0.1;
      v = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [DW-1:0] exp);
      logic [DW-1:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
      repeat (LAT) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic chk_time(input string req, input longint total);
      rd_chk(req, A_SEC, DW'(total >> FW));
      rd_chk(req, A_FRAC, DW'(total & ((1 << FW) - 1)));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      longint total;
      logic [DW-1:0] s1, s2, ien;

      repeat (3) @(negedge clk);
      // R1 reset state
      rd_chk("R1 sec",   A_SEC,   32'h0);
      rd_chk("R1 frac",  A_FRAC,  32'h0);
      rd_chk("R1 asec",  A_ASEC,  32'hFFFF_FFFF);
      rd_chk("R1 afrac", A_AFRAC, 32'h0);
      rd_chk("R1 ctrl",  A_CTRL,  32'h0);
      rd_chk("R1 stat",  A_STAT,  32'h0000_0202);
      rd_chk("R1 ien",   A_IEN,   32'h0);
      check("R1 irq", DW'(irq), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk("R1 stat after release", A_STAT, 32'h0000_0202);

      // R2 latency window, sampled every cycle
      @(negedge clk);
      bus_addr = A_AFRAC; bus_wdata = 32'd7; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
      for (int c = 0; c < LAT; c++) begin
         rd_chk("R2 busy window stat", A_STAT, 32'h0000_0402);
         rd_chk("R2 target held", A_AFRAC, 32'h0);
         @(negedge clk);
      end
      rd_chk("R2 completion stat", A_STAT, 32'h0000_0302);
      rd_chk("R2 target updated", A_AFRAC, 32'd7);

      // R3 write inside busy window is dropped
      @(negedge clk);
      bus_addr = A_ASEC; bus_wdata = 32'd100; bus_wen = 1'b1;
      @(negedge clk);
      bus_addr = A_AFRAC; bus_wdata = 32'd3;
      @(negedge clk);
      bus_wen = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      rd_chk("R3 first write landed", A_ASEC, 32'd100);
      rd_chk("R3 second write dropped", A_AFRAC, 32'd7);
      rd_chk("R3 error flag", A_STAT, 32'h0000_0382);
      wr(A_STAT, 32'h80);
      rd_chk("R4 error cleared", A_STAT, 32'h0000_0302);
      wr(A_ASEC, 32'hFFFF_FFFF);

      // R5 enable alone does not count
      wr(A_CTRL, 32'h8);
      ticks(5);
      chk_time("R5 non-valid holds time", 0);
      // R4 non-valid needs both bits
      wr(A_STAT, 32'h2);
      rd_chk("R4 nv alone kept", A_STAT, 32'h0000_0302);
      wr(A_STAT, 32'h3);
      rd_chk("R4 nv cleared", A_STAT, 32'h0000_0300);
      ticks(5);
      chk_time("R5 unloaded holds time", 0);

      // R6 fraction and seconds sweep
      wr(A_FRAC, 32'd9);
      wr(A_SEC, 32'd5);
      total = 5 * 16 + 9;
      chk_time("R6 seconds write keeps fraction", total);
      for (int n = 1; n <= 6; n++) begin
         ticks(n);
         total += n;
         chk_time("R6 tick sweep", total);
      end
      wr(A_SEC, 32'd2);
      total = 2 * 16 + (total & 15);
      chk_time("R6 seconds rewrite keeps fraction", total);

      // R5 control disable stops counting
      wr(A_CTRL, 32'h0);
      ticks(4);
      chk_time("R5 disabled holds time", total);

      // R7 alarm match
      wr(A_AFRAC, DW'((total + 3) & 15));
      wr(A_ASEC, DW'((total + 3) >> 4));
      wr(A_CTRL, 32'h8);
      ticks(2);
      @(negedge clk);
      rd_chk("R7 before match", A_STAT, 32'h0000_0300);
      ticks(1);
      @(negedge clk);
      rd_chk("R7 at match", A_STAT, 32'h0000_0310);
      ticks(2);
      rd_chk("R7 sticky", A_STAT, 32'h0000_0310);
      wr(A_STAT, 32'h10);
      rd_chk("R4 alarm cleared", A_STAT, 32'h0000_0300);

      // R7 unset alarm at seconds all ones, R6 seconds wrap
      wr(A_ASEC, 32'hFFFF_FFFF);
      wr(A_AFRAC, 32'd15);
      wr(A_CTRL, 32'h0);
      wr(A_FRAC, 32'd14);
      wr(A_SEC, 32'hFFFF_FFFF);
      wr(A_CTRL, 32'h8);
      ticks(1);
      @(negedge clk);
      rd_chk("R7 unset alarm silent", A_STAT, 32'h0000_0300);
      rd_chk("R7 reached all ones", A_SEC, 32'hFFFF_FFFF);
      ticks(1);
      chk_time("R6 seconds wrap", 0);

      // R8 interrupt enable sweep with done=1, next=1, err=1, alarm=0
      @(negedge clk);
      bus_addr = A_CTRL; bus_wdata = 32'h8; bus_wen = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_wen = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      rd_chk("R3 error again", A_STAT, 32'h0000_0380);
      for (int i = 0; i < 16; i++) begin
         ien = (DW'(i >> 3 & 1) << 9) | (DW'(i >> 2 & 1) << 8) |
               (DW'(i >> 1 & 1) << 7) | (DW'(i & 1) << 4);
         wr(A_IEN, ien | 32'hFFFF_FC6F);
         rd_chk("R9 ien readback masked", A_IEN, ien);
         check("R8 irq sweep", DW'(irq), DW'(((i >> 3) | (i >> 2) | (i >> 1)) & 1));
      end

      // R9 reads have no side effects
      rd_chk("R9 offset 7", 3'd7, 32'h0);
      rd_chk("R9 ctrl only run bit", A_CTRL, 32'h8);
      rd(A_STAT, s1);
      @(negedge clk);
      rd(A_STAT, s2);
      check("R9 repeated status read", s2, s1);
      check("R9 error survives reads", s2, 32'h0000_0380);

      // R10 violation
      @(negedge clk);
      viol_in = 1'b1;
      @(negedge clk);
      viol_in = 1'b0;
      rd_chk("R10 violation flags", A_STAT, 32'h0000_0383);
      ticks(3);
      chk_time("R10 counter stopped", 0);
      wr(A_STAT, 32'h1);
      rd_chk("R4 sv alone clears sv only", A_STAT, 32'h0000_0382);
      wr(A_STAT, 32'h3);
      rd_chk("R4 valid again", A_STAT, 32'h0000_0380);
      ticks(2);
      chk_time("R10 resumes after exit", 2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule